// File: doc/BRIEF.md
# Grouped Interrupt Status Aggregator

This block gathers single-cycle event pulses from four functional areas of a link controller: link/physical layer, isochronous transmit, isochronous receive and asynchronous. It keeps them in four status registers. Each status bit has its own enable bit. All status bits that are both pending and enabled are combined into one active-low interrupt line to the host. A summary register shows which areas are requesting at the moment. Its bits are not latched, so the host never has to acknowledge them.

The host reaches the registers through a plain read/write port. A read is issued with `rd_en_i` and its data comes back one cycle later, flagged by `rd_valid_o`. The host clears a status bit by writing 1 to it. A write of 0 to a status bit has no effect, so one write can acknowledge several bits without touching the others. Register addresses (ADDR_W = 4, AREA_W = 8, four areas):

- 0 to 3: status of areas 0 to 3.
- 4 to 7: enables of areas 0 to 3.
- 8: summary.
- Any other address reads as zero.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status register, every enable register and the summary read as zero, and `irq_n_o` is high.
- R2: An event pulse on bit b of area a sets status bit b of area a at the next clock edge. This happens whether or not that bit is enabled.
- R3: A write to status address a clears each bit of that area whose data bit is 1. Bits written with 0 keep their value.
- R4: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Enable address 4+a is a plain read/write register. Bit b of it is the enable of status bit b of area a.
- R6: `irq_n_o` is low exactly when at least one status bit of any area is set and enabled.
- R7: Summary bit a (address 8, bits 3:0) is 1 exactly when area a has a set and enabled status bit. The bit drops as soon as that condition ends, with no write to the summary. Summary bits 7:4 read 0.
- R8: The summary register is read-only. A write to address 8 changes no status, enable or summary value.
- R9: The areas are ordered as follows, both in `evt_i` lanes (lane a is bits 8a+7:8a) and in status and summary positions:
  - area 0: link/physical layer
  - area 1: isochronous transmit
  - area 2: isochronous receive
  - area 3: asynchronous

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously inside the block |
| evt_i | input | 32 | Event pulses, one 8-bit lane per area |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one cycle after `rd_en_i` |
| rd_valid_o | output | 1 | Marks `rdata_o` as valid |
| irq_n_o | output | 1 | Active-low interrupt to the host |

## Verification
The hardest case to reach from the ports is an event pulse landing on a bit in exactly the cycle that a clear write targets the same bit. The stimulus task therefore drives an event lane and a write strobe together on one falling edge. It then reads the status back and expects the bit still set.

The non-latching summary also needs care. It is checked by removing an area's request in two ways, a status clear and an enable drop. After each, the summary and the interrupt line are read back without any write to the summary address.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_AREAS    = 4;
  localparam int AREA_LINKPHY = 0;
  localparam int AREA_ISO_TX  = 1;
  localparam int AREA_ISO_RX  = 2;
  localparam int AREA_ASYNC   = 3;
  localparam int STAT_BASE    = 0;
  localparam int EN_BASE      = NUM_AREAS;
  localparam int SUMMARY_ADDR = 2 * NUM_AREAS;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/irq_area_reg.sv
module irq_area_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         req_o
);
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] enable_q, enable_d;
  logic         status_ce;

  // event has priority over clear
  always_comb begin
    status_ce = (|evt_i) | (|clr_i);
    status_d  = (status_q & ~clr_i) | evt_i;
    enable_d  = en_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      if (status_ce) status_q <= status_d;
      if (en_we_i)   enable_q <= enable_d;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign req_o    = |(status_q & enable_q);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~evt_i) != '0) |=> ((status_o & $past(clr_i & ~evt_i)) == '0));

  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i == '0) && (evt_i == '0)) |=> $stable(status_o));

  p_en_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we_i |=> $stable(enable_o));
endmodule

// File: rtl/irq_host_port.sv
module irq_host_port
  import irq_agg_pkg::*;
#(
  parameter int NA     = NUM_AREAS,
  parameter int W      = 8,
  parameter int ADDR_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]    wdata_i,
  input  logic [NA*W-1:0] status_all_i,
  input  logic [NA*W-1:0] enable_all_i,
  input  logic [NA-1:0]   req_i,
  output logic [NA*W-1:0] clr_all_o,
  output logic [NA-1:0]   en_we_o,
  output logic [W-1:0]    rdata_o,
  output logic            rd_valid_o
);
  localparam logic [ADDR_W-1:0] SUM_A = ADDR_W'(SUMMARY_ADDR);

  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q;
  logic         rd_valid_q;

  for (genvar a = 0; a < NA; a++) begin : g_dec
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STAT_BASE + a);
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_BASE + a);
    assign clr_all_o[a*W +: W] = (wr_en_i && addr_i == ST_A) ? wdata_i : '0;
    assign en_we_o[a]          = wr_en_i && (addr_i == EN_A);
  end

  always_comb begin
    rd_mux = '0;
    for (int a = 0; a < NA; a++) begin
      if (addr_i == ADDR_W'(STAT_BASE + a)) rd_mux = status_all_i[a*W +: W];
      if (addr_i == ADDR_W'(EN_BASE + a))   rd_mux = enable_all_i[a*W +: W];
    end
    if (addr_i == SUM_A) rd_mux = W'(req_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_valid_o = rd_valid_q;

  p_summary_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == SUM_A) |-> ((clr_all_o == '0) && (en_we_o == '0)));

  p_one_enable_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_we_o));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int AREA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_AREAS*AREA_W-1:0] evt_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [AREA_W-1:0]          wdata_i,
  output logic [AREA_W-1:0]          rdata_o,
  output logic                       rd_valid_o,
  output logic                       irq_n_o
);
  localparam int TOT_W = NUM_AREAS * AREA_W;

  logic             rst_sync_n;
  logic [TOT_W-1:0] stat_all;
  logic [TOT_W-1:0] en_all;
  logic [TOT_W-1:0] clr_all;
  logic [NUM_AREAS-1:0] en_we;
  logic [NUM_AREAS-1:0] area_req;

  irq_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
    irq_area_reg #(.W(AREA_W)) u_area (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .evt_i      (evt_i[a*AREA_W +: AREA_W]),
      .clr_i      (clr_all[a*AREA_W +: AREA_W]),
      .en_we_i    (en_we[a]),
      .en_wdata_i (wdata_i),
      .status_o   (stat_all[a*AREA_W +: AREA_W]),
      .enable_o   (en_all[a*AREA_W +: AREA_W]),
      .req_o      (area_req[a])
    );
  end

  irq_host_port #(.NA(NUM_AREAS), .W(AREA_W), .ADDR_W(ADDR_W)) u_port (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .status_all_i (stat_all),
    .enable_all_i (en_all),
    .req_i        (area_req),
    .clr_all_o    (clr_all),
    .en_we_o      (en_we),
    .rdata_o      (rdata_o),
    .rd_valid_o   (rd_valid_o)
  );

  assign irq_n_o = ~(|area_req);

  p_irq_matches_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_n_o == ((stat_all & en_all) == '0));

  p_irq_idle_in_reset_r1: assert property (@(posedge clk)
    !rst_sync_n |-> irq_n_o);
endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  localparam int NA = 4;
  localparam int W  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NA*W-1:0] evt;
  logic          wr_en, rd_en;
  logic [3:0]    addr;
  logic [W-1:0]  wdata;
  logic [W-1:0]  rdata;
  logic          rd_valid;
  logic          irq_n;

  int n_chk  = 0;
  int n_fail = 0;

  logic [W-1:0] m_stat [NA];
  logic [W-1:0] m_en   [NA];

  logic [W-1:0] exp_q [$];
  string        tag_q [$];

  always #2 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .irq_n_o(irq_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] m_summary();
    logic [W-1:0] s = '0;
    for (int a = 0; a < NA; a++) s[a] = |(m_stat[a] & m_en[a]);
    return s;
  endfunction

  function automatic logic [W-1:0] m_read(input int ad);
    if (ad < NA) return m_stat[ad];
    if (ad < 2*NA) return m_en[ad-NA];
    if (ad == 2*NA) return m_summary();
    return '0;
  endfunction

  // monitor: pops expected read data as results arrive
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "unexpected read", int'(rdata), 0);
      else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata === e, t, int'(rdata), int'(e));
      end
    end
  end

  // one bus cycle: events and optional write in the same cycle
  task automatic drive(input logic [NA*W-1:0] ev, input bit wr, input int ad, input logic [W-1:0] d);
    @(negedge clk);
    evt = ev; wr_en = wr; addr = 4'(ad); wdata = d;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    if (wr && ad < NA) m_stat[ad] = m_stat[ad] & ~d;
    if (wr && ad >= NA && ad < 2*NA) m_en[ad-NA] = d;
    for (int a = 0; a < NA; a++) m_stat[a] = m_stat[a] | ev[a*W +: W];
  endtask

  task automatic rd(input int ad, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(ad);
    exp_q.push_back(m_read(ad));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    logic e;
    e = (m_summary() == '0);
    check(irq_n === e, tag, int'(irq_n), int'(e));
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(1'b0, "reads lost", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < NA; a++) begin m_stat[a] = '0; m_en[a] = '0; end
    rst_n = 1'b0; evt = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int ad = 0; ad <= 2*NA; ad++) rd(ad, "R1 reset value");
    chk_irq("R1 irq_n idle");

    // R2 / R9: event on iso-tx lane latches while disabled
    drive(32'h0000_0500, 1'b0, 0, '0);
    rd(1, "R2 status latched while disabled");
    rd(0, "R9 other area untouched");
    rd(8, "R7 summary with nothing enabled");
    chk_irq("R6 disabled bit gives no irq");

    // R5: enable write and read back
    drive('0, 1'b1, 5, 8'h04);
    rd(5, "R5 enable read back");
    rd(8, "R7 summary area1");
    chk_irq("R6 enabled pending asserts irq");

    // R3: write zero no effect, then write one clears
    drive('0, 1'b1, 1, 8'h00);
    rd(1, "R3 write 0 keeps bits");
    drive('0, 1'b1, 1, 8'h04);
    rd(1, "R3 write 1 clears bit");
    rd(8, "R7 summary drops without ack");
    chk_irq("R6 irq released after clear");

    // R4: event and clear in same cycle on async area
    drive('0, 1'b1, 7, 8'h80);
    drive(32'h8000_0000, 1'b1, 3, 8'h80);
    rd(3, "R4 event wins over clear");
    rd(8, "R9 async is summary bit 3");
    chk_irq("R6 irq from async area");
    drive('0, 1'b1, 3, 8'h80);
    rd(3, "R3 async cleared");

    // R8: summary is read only
    drive(32'h0000_0001, 1'b0, 0, '0);
    drive('0, 1'b1, 4, 8'h01);
    drive('0, 1'b1, 8, 8'hFF);
    rd(8, "R8 summary unchanged by write");
    rd(0, "R8 status unchanged by summary write");
    rd(4, "R8 enable unchanged by summary write");

    // R7: dropping the enable drops the summary, status stays
    drive('0, 1'b1, 4, 8'h00);
    rd(8, "R7 summary follows enable");
    rd(0, "R2 status kept after enable drop");
    chk_irq("R6 irq off after enable drop");

    // several areas at once
    drive(32'h0033_0011, 1'b0, 0, '0);
    drive('0, 1'b1, 4, 8'h10);
    drive('0, 1'b1, 6, 8'h20);
    rd(8, "R7 two areas requesting");
    rd(2, "R9 iso-rx lane");
    chk_irq("R6 multi-area irq");
    drive('0, 1'b1, 2, 8'hFF);
    rd(8, "R7 one area left");
    chk_irq("R6 irq held by remaining area");
    drive('0, 1'b1, 0, 8'hFF);
    rd(8, "R7 all clear");
    chk_irq("R6 irq released");

    finish_run();
  end
endmodule